// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Sequencer

This block keeps an asynchronous DRAM alive. After reset it waits out the power-up pause. It then issues a burst of wake-up RAS cycles and raises a ready flag for the access controller. From then on it raises a refresh need at a fixed interval and runs one refresh cycle for each need, whenever the access controller grants it the strobes and the address bus. Two refresh styles are available. In the CAS-first style, both column strobes fall before the row strobe, and the memory's own row counter picks the row. In the row-address style, an internal row counter drives the address bus while only the row strobe pulses.

Refresh needs that the access controller postpones are counted. A short backlog is worked off as back-to-back cycles once the grant returns. If the backlog grows past a limit, the memory is treated as having missed its retention deadline. The ready flag then drops and the full wake-up burst runs again. All times are parameters counted in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, `ras_n_o`, `lcas_n_o` and `ucas_n_o` are high, `addr_o` is zero, and `req_o`, `own_o` and `init_done_o` are low.
- R2: After reset is released, `req_o` stays low for exactly PAUSE_CYCLES clock edges and rises after edge number PAUSE_CYCLES.
- R3: A refresh cycle starts only on an edge where `req_o` and `gnt_i` are both high and no cycle is in progress. `own_o` rises on that edge. While `own_o` is low, all strobes are high and `addr_o` is zero. A started cycle always runs to completion.
- R4: With `ror_mode_i` = 0 (CAS-first style), a cycle holds both CAS strobes low for T_CSR cycles before RAS falls. CAS then stays low for T_CHR cycles after RAS falls. RAS is low for exactly T_RAS cycles, and `addr_o` stays zero.
- R5: With `ror_mode_i` = 1 (row-address style), RAS falls on the first owned cycle and is low for exactly T_RAS cycles. Both CAS strobes stay high. In both styles, RAS is high for exactly T_RP owned cycles of precharge before `own_o` falls.
- R6: In the row-address style, `addr_o` carries the internal row for the whole owned cycle. The row starts at 0 after reset and advances by one after each row-address cycle, wrapping from 255 to 0. CAS-first cycles leave it unchanged. The style is sampled when a cycle starts.
- R7: `init_done_o` rises on the edge that ends the WAKE_CYCLES-th (8th) wake-up cycle, which is the same edge on which `own_o` falls.
- R8: Once ready, a refresh need is added every TICK_CYCLES edges. `req_o` rises TICK_CYCLES edges after `init_done_o` rises.
- R9: Needs postponed by a withheld grant accumulate, up to OWED_LIMIT of them. When the grant returns, exactly that many cycles run back to back, and then `req_o` falls.
- R10: When the backlog reaches OWED_LIMIT+1, `init_done_o` falls on the next edge. WAKE_CYCLES wake-up cycles are then run again, the backlog is cleared, and the refresh timing restarts from the new ready point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ror_mode_i | input | 1 | 1 = row-address refresh, 0 = CAS-first refresh |
| gnt_i | input | 1 | Access controller hands the strobes and address bus to this block |
| req_o | output | 1 | Wake-up or refresh work is pending or in progress |
| own_o | output | 1 | A refresh or wake-up cycle is driving the strobes and bus |
| ras_n_o | output | 1 | Row strobe, active low |
| lcas_n_o | output | 1 | Lower column strobe, active low |
| ucas_n_o | output | 1 | Upper column strobe, active low |
| addr_o | output | ROW_W | Row address, valid in row-address cycles |
| init_done_o | output | 1 | Wake-up complete; normal access may proceed |

## Verification
Each result has a fixed due cycle. `req_o` rises PAUSE_CYCLES edges after reset release and TICK_CYCLES edges after each ready point. `own_o` rises on the first edge after a grant meets a pending need. RAS falls T_CSR owned cycles later in the CAS-first style and at once in the row-address style. `init_done_o` drops one edge after the backlog passes its limit. The bench counts falling-edge samples between these events and compares the counts with the parameter values. A monitor measures every strobe pulse against its width and checks every row address against a modulo-256 model that advances only on row-address cycles.

// File: rtl/dram_refresh_pkg.sv
`timescale 1ns/1ps
// Shared state encodings for the refresh and wake-up sequencer.
package dram_refresh_pkg;

    // Top-level lifecycle of the memory being kept alive.
    typedef enum logic [1:0] {
        ST_PAUSE,
        ST_WAKE,
        ST_RUN
    } seq_state_e;

    // Phases of one RAS cycle inside the strobe engine.
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CAS_SETUP,
        PH_RAS_LOW,
        PH_PRECHARGE
    } strobe_phase_e;

endpackage

// File: rtl/refresh_interval_timer.sv
`timescale 1ns/1ps
// Free-running interval counter. While en is high it pulses fire once every
// PERIOD cycles. It holds at zero while en is low, so the first pulse comes
// PERIOD cycles after en rises. Assumes PERIOD >= 2.
module refresh_interval_timer #(
    parameter int PERIOD = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic fire
);
    localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [W-1:0] cnt;

    assign fire = en && (cnt == W'(PERIOD - 1));

    // Count enabled cycles; restart on wrap or when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || fire) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/refresh_owed_tracker.sv
`timescale 1ns/1ps
// Backlog of refreshes that are due but not yet done. The count saturates at
// LIMIT+1, and reaching that value raises overdue. An increment and a
// decrement on the same cycle cancel out. clr has priority over both.
module refresh_owed_tracker #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic pending,
    output logic overdue
);
    localparam int CAP = LIMIT + 1;
    localparam int W   = $clog2(CAP + 1);

    logic [W-1:0] owed;

    assign pending = (owed != '0);
    assign overdue = (owed > W'(LIMIT));

    // Saturating up/down count of owed refreshes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                         owed <= '0;
        else if (inc && !dec && owed != W'(CAP))   owed <= owed + 1'b1;
        else if (dec && !inc && owed != '0)        owed <= owed - 1'b1;
    end
endmodule

// File: rtl/refresh_row_counter.sv
`timescale 1ns/1ps
// Row pointer for row-address refresh. It advances by one on each inc and
// wraps naturally at 2**ROW_W.
module refresh_row_counter #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ROW_W-1:0] row
);
    // Step the row after each completed row-address cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   row <= '0;
        else if (inc) row <= row + 1'b1;
    end
endmodule

// File: rtl/refresh_strobe_engine.sv
`timescale 1ns/1ps
// Runs one complete RAS cycle per start pulse. In the CAS-first style it
// drives CAS setup, then RAS low (CAS held for T_CHR), then precharge. In the
// row-address style it skips CAS setup and drives the row on addr. The style
// is latched at start. Assumes T_CSR >= 1, T_RP >= 1, and
// 1 <= T_CHR < T_RAS. start is ignored while busy.
module refresh_strobe_engine
    import dram_refresh_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int T_CSR = 1,
    parameter int T_CHR = 1,
    parameter int T_RAS = 3,
    parameter int T_RP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ror_sel,
    input  logic [ROW_W-1:0] row,
    output logic             busy,
    output logic             done,
    output logic             cyc_ror,
    output logic             ras_n,
    output logic             lcas_n,
    output logic             ucas_n,
    output logic [ROW_W-1:0] addr
);
    localparam int M1    = (T_CSR > T_RAS) ? T_CSR : T_RAS;
    localparam int M2    = (T_RP > M1) ? T_RP : M1;
    localparam int CNT_W = $clog2(M2 + 1);

    strobe_phase_e     ph;
    logic [CNT_W-1:0]  cnt;
    logic              ror_q;
    logic              last;
    logic              cas_low;

    // Detect the final cycle of the current phase.
    always_comb begin
        unique case (ph)
            PH_CAS_SETUP: last = (cnt == CNT_W'(T_CSR - 1));
            PH_RAS_LOW:   last = (cnt == CNT_W'(T_RAS - 1));
            PH_PRECHARGE: last = (cnt == CNT_W'(T_RP - 1));
            default:      last = 1'b0;
        endcase
    end

    // Phase sequencing and per-phase cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            ror_q <= 1'b0;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph    <= ror_sel ? PH_RAS_LOW : PH_CAS_SETUP;
                        ror_q <= ror_sel;
                        cnt   <= '0;
                    end
                end
                PH_CAS_SETUP: begin
                    if (last) begin ph <= PH_RAS_LOW;   cnt <= '0; end
                    else            cnt <= cnt + 1'b1;
                end
                PH_RAS_LOW: begin
                    if (last) begin ph <= PH_PRECHARGE; cnt <= '0; end
                    else            cnt <= cnt + 1'b1;
                end
                PH_PRECHARGE: begin
                    if (last) begin ph <= PH_IDLE;      cnt <= '0; end
                    else            cnt <= cnt + 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Strobe and address decode from the phase register.
    always_comb begin
        cas_low = !ror_q &&
                  ((ph == PH_CAS_SETUP) ||
                   ((ph == PH_RAS_LOW) && (cnt < CNT_W'(T_CHR))));
        ras_n   = (ph != PH_RAS_LOW);
        lcas_n  = !cas_low;
        ucas_n  = !cas_low;
        addr    = (ror_q && ph != PH_IDLE) ? row : '0;
        busy    = (ph != PH_IDLE);
        done    = (ph == PH_PRECHARGE) && last;
        cyc_ror = ror_q;
    end
endmodule

// File: rtl/dram_refresh_seq.sv
`timescale 1ns/1ps
// Refresh and wake-up sequencer for an asynchronous DRAM. After reset it
// waits PAUSE_CYCLES, runs WAKE_CYCLES RAS cycles, then raises init_done_o
// and issues one refresh per TICK_CYCLES. It requests the bus with req_o and
// starts a cycle only when gnt_i is high. Assumes the access controller keeps
// gnt_i high while own_o is high. A backlog above OWED_LIMIT reruns wake-up.
module dram_refresh_seq
    import dram_refresh_pkg::*;
#(
    parameter int ROW_W        = 8,
    parameter int TICK_CYCLES  = 780,
    parameter int PAUSE_CYCLES = 10000,
    parameter int WAKE_CYCLES  = 8,
    parameter int T_CSR        = 1,
    parameter int T_CHR        = 1,
    parameter int T_RAS        = 3,
    parameter int T_RP         = 2,
    parameter int OWED_LIMIT   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ror_mode_i,
    input  logic             gnt_i,
    output logic             req_o,
    output logic             own_o,
    output logic             ras_n_o,
    output logic             lcas_n_o,
    output logic             ucas_n_o,
    output logic [ROW_W-1:0] addr_o,
    output logic             init_done_o
);
    localparam int WK_W = $clog2(WAKE_CYCLES + 1);

    seq_state_e       st;
    logic [WK_W-1:0]  wake_cnt;
    logic             pause_fire;
    logic             tick;
    logic             owed_pending;
    logic             overdue;
    logic             pending;
    logic             start;
    logic             busy;
    logic             done;
    logic             cyc_ror;
    logic [ROW_W-1:0] row;

    assign pending     = (st == ST_WAKE) || ((st == ST_RUN) && owed_pending);
    assign start       = pending && gnt_i && !busy;
    assign req_o       = pending || busy;
    assign own_o       = busy;
    assign init_done_o = (st == ST_RUN);

    // Lifecycle: pause, wake-up burst, refresh service, re-wake on overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_PAUSE;
            wake_cnt <= '0;
        end else begin
            unique case (st)
                ST_PAUSE: if (pause_fire) st <= ST_WAKE;
                ST_WAKE: begin
                    if (done) begin
                        if (wake_cnt == WK_W'(WAKE_CYCLES - 1)) begin
                            st       <= ST_RUN;
                            wake_cnt <= '0;
                        end else begin
                            wake_cnt <= wake_cnt + 1'b1;
                        end
                    end
                end
                ST_RUN:   if (overdue) st <= ST_WAKE;
                default:  st <= ST_PAUSE;
            endcase
        end
    end

    refresh_interval_timer #(.PERIOD(PAUSE_CYCLES)) pause_tmr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (st == ST_PAUSE),
        .fire (pause_fire)
    );

    refresh_interval_timer #(.PERIOD(TICK_CYCLES)) tick_tmr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (st == ST_RUN),
        .fire (tick)
    );

    refresh_owed_tracker #(.LIMIT(OWED_LIMIT)) owed_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (st != ST_RUN),
        .inc    (tick),
        .dec    (done),
        .pending(owed_pending),
        .overdue(overdue)
    );

    refresh_row_counter #(.ROW_W(ROW_W)) row_i (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (done && cyc_ror),
        .row  (row)
    );

    refresh_strobe_engine #(
        .ROW_W(ROW_W),
        .T_CSR(T_CSR),
        .T_CHR(T_CHR),
        .T_RAS(T_RAS),
        .T_RP (T_RP)
    ) eng_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .ror_sel(ror_mode_i),
        .row    (row),
        .busy   (busy),
        .done   (done),
        .cyc_ror(cyc_ror),
        .ras_n  (ras_n_o),
        .lcas_n (lcas_n_o),
        .ucas_n (ucas_n_o),
        .addr   (addr_o)
    );
endmodule

// File: rtl/dram_refresh_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for dram_refresh_seq, attached by bind. It measures RAS
// low and high run lengths with counters, so no wide $past windows are used.
module dram_refresh_seq_chk #(
    parameter int ROW_W = 8,
    parameter int T_RAS = 3,
    parameter int T_RP  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gnt_i,
    input logic             req_o,
    input logic             own_o,
    input logic             ras_n_o,
    input logic             lcas_n_o,
    input logic             ucas_n_o,
    input logic [ROW_W-1:0] addr_o,
    input logic             init_done_o
);
    logic [15:0] low_cnt;
    logic [15:0] hi_cnt;

    // Length of the current RAS-low run.
    always_ff @(posedge clk) begin
        if (!rst_n || ras_n_o)       low_cnt <= '0;
        else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
    end

    // Length of the current RAS-high run, saturating at T_RP.
    always_ff @(posedge clk) begin
        if (!rst_n || !ras_n_o)         hi_cnt <= '0;
        else if (hi_cnt < 16'(T_RP))    hi_cnt <= hi_cnt + 1'b1;
    end

    p_idle_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !own_o |-> (ras_n_o && lcas_n_o && ucas_n_o && addr_o == '0));

    p_start_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_o) |-> $past(gnt_i));

    p_own_requests_r3: assert property (@(posedge clk) disable iff (!rst_n)
        own_o |-> req_o);

    p_cas_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lcas_n_o == ucas_n_o);

    p_cas_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && !lcas_n_o) |-> $past(!lcas_n_o));

    p_ras_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> (low_cnt == 16'(T_RAS)));

    p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> (hi_cnt >= 16'(T_RP)));

    p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done_o) |-> !own_o);

    p_rewake_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_done_o) |-> req_o);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
    .ROW_W(ROW_W),
    .T_RAS(T_RAS),
    .T_RP (T_RP)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .gnt_i      (gnt_i),
    .req_o      (req_o),
    .own_o      (own_o),
    .ras_n_o    (ras_n_o),
    .lcas_n_o   (lcas_n_o),
    .ucas_n_o   (ucas_n_o),
    .addr_o     (addr_o),
    .init_done_o(init_done_o)
);

// File: tb/dram_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb_top;
    localparam int ROW_W = 8;
    localparam int TICK  = 40;
    localparam int PAUSE = 20;
    localparam int WAKE  = 8;
    localparam int TCSR  = 2;
    localparam int TCHR  = 2;
    localparam int TRAS  = 4;
    localparam int TRP   = 3;
    localparam int LIMIT = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ror_mode;
    logic             gnt;
    logic             req, own, ras_n, lcas_n, ucas_n, init_done;
    logic [ROW_W-1:0] addr;

    int checks = 0;
    int errors = 0;

    dram_refresh_seq #(
        .ROW_W(ROW_W), .TICK_CYCLES(TICK), .PAUSE_CYCLES(PAUSE),
        .WAKE_CYCLES(WAKE), .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS),
        .T_RP(TRP), .OWED_LIMIT(LIMIT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ror_mode_i(ror_mode), .gnt_i(gnt),
        .req_o(req), .own_o(own), .ras_n_o(ras_n), .lcas_n_o(lcas_n),
        .ucas_n_o(ucas_n), .addr_o(addr), .init_done_o(init_done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Pulse monitor: measures every owned cycle against the parameters.
    bit              mon_on = 1'b0;
    bit              exp_ror = 1'b0;
    logic [ROW_W-1:0] exp_row = '0;
    int              pulses = 0;
    int              lead = 0, lowc = 0, holdc = 0, hic = 0;
    bit              in_pre = 1'b0;
    logic            prev_ras = 1'b1, prev_own = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            chk(lcas_n == ucas_n, "R4 cas pair", int'(ucas_n), int'(lcas_n));
            if (!own)
                chk(ras_n && lcas_n && ucas_n && addr == '0, "R3 idle bus",
                    int'({ras_n, lcas_n, ucas_n}), 7);
            if (prev_ras && !ras_n) begin
                if (exp_ror) begin
                    chk(lcas_n, "R5 cas high", int'(lcas_n), 1);
                    chk(lead == 0, "R5 no cas lead", lead, 0);
                    chk(addr == exp_row, "R6 row", int'(addr), int'(exp_row));
                end else begin
                    chk(!lcas_n, "R4 cas low at ras fall", int'(lcas_n), 0);
                    chk(lead == TCSR, "R4 cas setup", lead, TCSR);
                    chk(addr == '0, "R4 addr zero", int'(addr), 0);
                end
                lowc  = 1;
                holdc = lcas_n ? 0 : 1;
                lead  = 0;
            end else if (!ras_n) begin
                lowc++;
                if (!lcas_n) holdc++;
                if (exp_ror) chk(addr == exp_row, "R6 row held", int'(addr), int'(exp_row));
            end else if (!prev_ras && ras_n) begin
                chk(lowc == TRAS, "R4 ras width", lowc, TRAS);
                if (!exp_ror) chk(holdc == TCHR, "R4 cas hold", holdc, TCHR);
                pulses++;
                if (exp_ror) exp_row++;
                hic    = 1;
                in_pre = 1'b1;
            end else if (own) begin
                if (in_pre) hic++;
                else        lead++;
            end
            if (prev_own && !own) begin
                chk(hic == TRP, "R5 precharge", hic, TRP);
                in_pre = 1'b0;
                lead   = 0;
                hic    = 0;
            end
            prev_ras = ras_n;
            prev_own = own;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        int p0;
        rst_n = 1'b0; gnt = 1'b0; ror_mode = 1'b0;
        repeat (3) step();
        // R1: reset state
        chk(ras_n && lcas_n && ucas_n, "R1 strobes", int'({ras_n, lcas_n, ucas_n}), 7);
        chk(addr == '0, "R1 addr", int'(addr), 0);
        chk(!req && !own && !init_done, "R1 flags", int'({req, own, init_done}), 0);
        rst_n   = 1'b1;
        mon_on  = 1'b1;

        // R2: pause length
        n = 0;
        while (!req) begin step(); n++; end
        chk(n == PAUSE, "R2 pause", n, PAUSE);
        // R3: no ownership without grant
        repeat (3) step();
        chk(!own, "R3 wait grant", int'(own), 0);
        gnt = 1'b1;
        step();
        chk(own, "R3 own after grant", int'(own), 1);

        // R7: ready after exactly WAKE cycles
        while (!init_done) step();
        chk(pulses == WAKE, "R7 wake count", pulses, WAKE);
        chk(!own, "R7 bus free at ready", int'(own), 0);

        // R8: first tick
        n = 0;
        while (!req) begin step(); n++; end
        chk(n == TICK, "R8 tick interval", n, TICK);
        step();
        chk(own, "R3 start on grant", int'(own), 1);
        while (own) step();
        chk(pulses == WAKE + 1, "R8 one refresh", pulses, WAKE + 1);

        // R9: postponed backlog worked off back to back
        gnt = 1'b0;
        while (!req) step();
        repeat (2 * TICK + 2) step();
        chk(pulses == WAKE + 1, "R9 no cycles while denied", pulses, WAKE + 1);
        chk(init_done, "R9 still ready", int'(init_done), 1);
        gnt = 1'b1;
        p0 = pulses;
        while (req) step();
        chk(pulses - p0 == LIMIT, "R9 backlog", pulses - p0, LIMIT);
        repeat (5) step();
        chk(!req && pulses - p0 == LIMIT, "R9 no extra", pulses - p0, LIMIT);

        // R10: overrun triggers re-wake
        gnt = 1'b0;
        while (!req) step();
        repeat (3 * TICK) step();
        chk(init_done, "R10 ready before overrun", int'(init_done), 1);
        step();
        chk(!init_done, "R10 ready drops", int'(init_done), 0);
        chk(req, "R10 wake request", int'(req), 1);
        gnt = 1'b1;
        p0 = pulses;
        while (!init_done) step();
        chk(pulses - p0 == WAKE, "R10 rewake count", pulses - p0, WAKE);
        n = 0;
        while (!req) begin step(); n++; end
        chk(n == TICK, "R10 backlog cleared", n, TICK);
        while (req) step();

        // R5, R6: row-address style with wrap
        ror_mode = 1'b1; exp_ror = 1'b1;
        p0 = pulses;
        while (pulses - p0 < 258) step();
        while (own) step();
        while (!own) step();
        chk(addr == 8'd2, "R6 wrap", int'(addr), 2);
        while (own) step();

        // R6: CAS-first cycle leaves the row alone
        ror_mode = 1'b0; exp_ror = 1'b0;
        p0 = pulses;
        while (pulses == p0) step();
        while (own) step();
        ror_mode = 1'b1; exp_ror = 1'b1;
        while (!own) step();
        chk(addr == 8'd3, "R6 row kept across CAS-first", int'(addr), 3);
        while (own) step();
        repeat (4) step();
        finish_run();
    end
endmodule